// File: doc/BRIEF.md
# Floating-Point Register Pairing Access Unit

This block sits between the integer pipeline, the data memory port and a 32-entry, 64-bit floating-point register file. It decodes one transfer request per cycle and returns, one cycle later, everything the surrounding pipeline needs to finish the transfer. That covers the physical register to read and write, the merged 64-bit write value, the integer result of a move-out, the memory address and access size, the store data, and, for 32-bit loads, the shift amount and the preserved register half that the load return path merges with the fetched word.

The register file runs in one of two modes, chosen by the `wide_mode` input. The integrator connects this input to bit 26 of the processor status word (mask 0x04000000). With the bit set, every register number names its own independent 64-bit register. With the bit clear, the unit runs in paired mode, where a 32-bit access to an odd register number reaches the upper half of the even register just below it. The unit then merges on writes and shifts on loads and stores. Doubleword accesses ignore pairing in both modes.

The physical read index is produced combinationally from the request, so the register file can return the old register contents in the same cycle. The merge is built from that value.

Top module: `fpr_pair_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fpr_wr_en`, `gpr_wr_en` and `mem_valid` are all low.
- R2: In paired mode (`wide_mode`=0) a 32-bit operation (codes 0, 1, 4, 6) uses the register number with bit 0 cleared as both `fpr_rd_idx` and `fpr_dst_idx`. In 64-bit mode, and for every 64-bit operation (codes 2, 3, 5, 7) in either mode, the register number is used unchanged.
- R3: A 32-bit move into the register file in paired mode writes the low 32 bits of `gpr_data` into bits 63:32 for an odd register and keeps bits 31:0 of `fpr_rd_data`. For an even register it writes them into bits 31:0 and keeps bits 63:32.
- R4: A 32-bit move into the register file in 64-bit mode writes the low 32 bits of `gpr_data`, sign-extended to 64 bits.
- R5: A 32-bit move out of the register file returns the selected word of `fpr_rd_data`, sign-extended to 64 bits. The selected word is bits 63:32 for an odd register in paired mode and bits 31:0 in every other case.
- R6: A 32-bit load gives `ld_shift`=32 and `ld_keep`={32'b0, fpr_rd_data[31:0]} for an odd register in paired mode. For an even register in paired mode it gives `ld_shift`=0 and `ld_keep`={fpr_rd_data[63:32], 32'b0}. In 64-bit mode it gives `ld_shift`=0 and `ld_keep`=0. A 64-bit load always gives a shift of 0 and a keep value of 0.
- R7: A 32-bit store puts `fpr_rd_data` shifted right by 32 on `mem_wdata` for an odd register in paired mode, and `fpr_rd_data` unshifted otherwise. A 64-bit store puts `fpr_rd_data` on `mem_wdata` unchanged.
- R8: Loads and stores drive `mem_addr` = `base_addr` + the sign-extended `offset_imm`, modulo 2^64. `mem_size` is 4 for the 32-bit forms and 8 for the 64-bit forms. `mem_write` is 1 for stores (codes 6, 7) and 0 for loads (codes 4, 5).
- R9: A 64-bit move in (code 2) writes `gpr_data` unchanged to the register. A 64-bit move out (code 3) returns `fpr_rd_data` unchanged on `gpr_wr_data`.
- R10: Operation codes on `req_op`: 0 move word in, 1 move word out, 2 move doubleword in, 3 move doubleword out, 4 load word, 5 load doubleword, 6 store word, 7 store doubleword. Each accepted request raises exactly one strobe in the next cycle: `fpr_wr_en` for codes 0 and 2, `gpr_wr_en` for codes 1 and 3, `mem_valid` for codes 4 to 7. A cycle without `req_valid` raises no strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present this cycle |
| req_op | input | 3 | Operation code (see R10) |
| wide_mode | input | 1 | Register mode: 1 = independent 64-bit registers, 0 = paired |
| reg_num | input | 5 | Architectural floating-point register number |
| fpr_rd_idx | output | 5 | Physical register to read this cycle |
| fpr_rd_data | input | 64 | Contents of the register named by `fpr_rd_idx` |
| gpr_data | input | 64 | Integer source operand |
| base_addr | input | 64 | Address base for loads and stores |
| offset_imm | input | 16 | Signed address offset |
| fpr_wr_en | output | 1 | Register-file write strobe |
| fpr_dst_idx | output | 5 | Physical destination register for writes and loads |
| fpr_wr_data | output | 64 | Merged register-file write value |
| gpr_wr_en | output | 1 | Integer result strobe |
| gpr_wr_data | output | 64 | Integer result |
| mem_valid | output | 1 | Memory access strobe |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 64 | Effective address |
| mem_size | output | 4 | Access size in bytes |
| mem_wdata | output | 64 | Store data, low-aligned |
| ld_shift | output | 6 | Left shift to apply to the returned load word |
| ld_keep | output | 64 | Preserved register bits to merge with the shifted load word |

## Verification
A wrong pairing decision is easy to spot. The even/odd choice made in the request cycle shows up one cycle later as a destination index with bit 0 set, as the wrong half of the old register value in the merged write, or as a shift that is off by 32 on a load or store. A stale or misrouted operand shows up as a mismatch in the output word in that same cycle. A decode fault raises the wrong strobe, or two strobes, on the very next edge. The bench mixes directed odd and even, paired and wide cases with seeded random traffic, so each of these faults surfaces within one request of its cause.

// File: rtl/fpr_pair_pkg.sv
package fpr_pair_pkg;

   typedef enum logic [2:0] {
      OP_MOVE_IN_W   = 3'd0,
      OP_MOVE_OUT_W  = 3'd1,
      OP_MOVE_IN_D   = 3'd2,
      OP_MOVE_OUT_D  = 3'd3,
      OP_LOAD_W      = 3'd4,
      OP_LOAD_D      = 3'd5,
      OP_STORE_W     = 3'd6,
      OP_STORE_D     = 3'd7
   } xfer_op_e;

   function automatic logic op_is_word(input xfer_op_e op);
      return (op == OP_MOVE_IN_W) || (op == OP_MOVE_OUT_W) ||
             (op == OP_LOAD_W)    || (op == OP_STORE_W);
   endfunction

   function automatic logic op_is_mem(input xfer_op_e op);
      return (op == OP_LOAD_W) || (op == OP_LOAD_D) ||
             (op == OP_STORE_W) || (op == OP_STORE_D);
   endfunction

   function automatic logic op_is_store(input xfer_op_e op);
      return (op == OP_STORE_W) || (op == OP_STORE_D);
   endfunction

   function automatic logic op_writes_fpr(input xfer_op_e op);
      return (op == OP_MOVE_IN_W) || (op == OP_MOVE_IN_D);
   endfunction

   function automatic logic op_writes_gpr(input xfer_op_e op);
      return (op == OP_MOVE_OUT_W) || (op == OP_MOVE_OUT_D);
   endfunction

endpackage

// File: rtl/fpr_pair_map.sv
module fpr_pair_map #(
   parameter int IDX_W = 5
) (
   input  logic             wide_mode,
   input  logic             word_op,
   input  logic [IDX_W-1:0] reg_num,
   output logic             hi_sel,
   output logic             paired,
   output logic [IDX_W-1:0] phys_idx
);

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("fpr_pair_map: IDX_W must be at least 2");
      end
   endgenerate

   logic fold;

   always_comb begin
      paired   = ~wide_mode;
      fold     = paired & word_op;
      hi_sel   = fold & reg_num[0];
      phys_idx = fold ? {reg_num[IDX_W-1:1], 1'b0} : reg_num;
   end

endmodule

// File: rtl/fpr_pair_lane.sv
module fpr_pair_lane
   import fpr_pair_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int SHIFT_W = $clog2(DATA_W)
) (
   input  xfer_op_e             op,
   input  logic                 paired,
   input  logic                 hi_sel,
   input  logic [DATA_W-1:0]    fpr_val,
   input  logic [DATA_W-1:0]    gpr_val,
   output logic [DATA_W-1:0]    fpr_wdata,
   output logic [DATA_W-1:0]    gpr_wdata,
   output logic [DATA_W-1:0]    st_data,
   output logic [DATA_W-1:0]    keep_data,
   output logic [SHIFT_W-1:0]   shift_amt
);

   localparam int HALF = DATA_W / 2;

   generate
      if ((DATA_W % 2) != 0 || DATA_W < 16) begin : g_bad_width
         $error("fpr_pair_lane: DATA_W must be even and at least 16");
      end
   endgenerate

   logic [HALF-1:0]   src_lo;
   logic [HALF-1:0]   reg_lo;
   logic [HALF-1:0]   reg_hi;
   logic [HALF-1:0]   sel_word;
   logic [DATA_W-1:0] move_in_w;
   logic [DATA_W-1:0] keep_w;

   always_comb begin
      src_lo   = gpr_val[HALF-1:0];
      reg_lo   = fpr_val[HALF-1:0];
      reg_hi   = fpr_val[DATA_W-1:HALF];
      sel_word = hi_sel ? reg_hi : reg_lo;

      if (!paired)
         move_in_w = {{HALF{src_lo[HALF-1]}}, src_lo};
      else if (hi_sel)
         move_in_w = {src_lo, reg_lo};
      else
         move_in_w = {reg_hi, src_lo};

      if (!paired)
         keep_w = '0;
      else if (hi_sel)
         keep_w = {{HALF{1'b0}}, reg_lo};
      else
         keep_w = {reg_hi, {HALF{1'b0}}};
   end

   always_comb begin
      fpr_wdata = gpr_val;
      gpr_wdata = fpr_val;
      st_data   = fpr_val;
      keep_data = '0;
      shift_amt = '0;
      unique case (op)
         OP_MOVE_IN_W:  fpr_wdata = move_in_w;
         OP_MOVE_OUT_W: gpr_wdata = {{HALF{sel_word[HALF-1]}}, sel_word};
         OP_LOAD_W: begin
            keep_data = keep_w;
            shift_amt = hi_sel ? SHIFT_W'(HALF) : '0;
         end
         OP_STORE_W:    st_data = hi_sel ? (fpr_val >> HALF) : fpr_val;
         default: ;
      endcase
   end

endmodule

// File: rtl/fpr_pair_agen.sv
module fpr_pair_agen #(
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] offset;

   generate
      if (ADDR_W > IMM_W) begin : g_sext
         assign offset = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_trunc
         assign offset = imm[ADDR_W-1:0];
      end
   endgenerate

   assign addr = base + offset;

endmodule

// File: rtl/fpr_pair_unit.sv
module fpr_pair_unit
   import fpr_pair_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 5,
   parameter int ADDR_W = 64,
   parameter int IMM_W  = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [2:0]                  req_op,
   input  logic                        wide_mode,
   input  logic [IDX_W-1:0]            reg_num,
   output logic [IDX_W-1:0]            fpr_rd_idx,
   input  logic [DATA_W-1:0]           fpr_rd_data,
   input  logic [DATA_W-1:0]           gpr_data,
   input  logic [ADDR_W-1:0]           base_addr,
   input  logic [IMM_W-1:0]            offset_imm,
   output logic                        fpr_wr_en,
   output logic [IDX_W-1:0]            fpr_dst_idx,
   output logic [DATA_W-1:0]           fpr_wr_data,
   output logic                        gpr_wr_en,
   output logic [DATA_W-1:0]           gpr_wr_data,
   output logic                        mem_valid,
   output logic                        mem_write,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic [3:0]                  mem_size,
   output logic [DATA_W-1:0]           mem_wdata,
   output logic [$clog2(DATA_W)-1:0]   ld_shift,
   output logic [DATA_W-1:0]           ld_keep
);

   localparam int HALF        = DATA_W / 2;
   localparam int SHIFT_W     = $clog2(DATA_W);
   localparam int WORD_BYTES  = HALF / 8;
   localparam int DWORD_BYTES = DATA_W / 8;

   generate
      if (DWORD_BYTES > 15 || (DATA_W % 16) != 0) begin : g_bad_size
         $error("fpr_pair_unit: DATA_W must be a multiple of 16 and at most 120");
      end
   endgenerate

   xfer_op_e          op;
   logic              word_op;
   logic              hi_sel;
   logic              paired;
   logic [IDX_W-1:0]  phys_idx;
   logic [DATA_W-1:0] n_fpr_wdata;
   logic [DATA_W-1:0] n_gpr_wdata;
   logic [DATA_W-1:0] n_st_data;
   logic [DATA_W-1:0] n_keep;
   logic [SHIFT_W-1:0] n_shift;
   logic [ADDR_W-1:0] n_addr;

   assign op      = xfer_op_e'(req_op);
   assign word_op = op_is_word(op);

   fpr_pair_map #(.IDX_W(IDX_W)) u_map (
      .wide_mode (wide_mode),
      .word_op   (word_op),
      .reg_num   (reg_num),
      .hi_sel    (hi_sel),
      .paired    (paired),
      .phys_idx  (phys_idx)
   );

   assign fpr_rd_idx = phys_idx;

   fpr_pair_lane #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_lane (
      .op        (op),
      .paired    (paired),
      .hi_sel    (hi_sel),
      .fpr_val   (fpr_rd_data),
      .gpr_val   (gpr_data),
      .fpr_wdata (n_fpr_wdata),
      .gpr_wdata (n_gpr_wdata),
      .st_data   (n_st_data),
      .keep_data (n_keep),
      .shift_amt (n_shift)
   );

   fpr_pair_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
      .base (base_addr),
      .imm  (offset_imm),
      .addr (n_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fpr_wr_en <= 1'b0;
         gpr_wr_en <= 1'b0;
         mem_valid <= 1'b0;
         mem_write <= 1'b0;
      end else begin
         fpr_wr_en <= req_valid & op_writes_fpr(op);
         gpr_wr_en <= req_valid & op_writes_gpr(op);
         mem_valid <= req_valid & op_is_mem(op);
         mem_write <= req_valid & op_is_store(op);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fpr_dst_idx <= '0;
         fpr_wr_data <= '0;
         gpr_wr_data <= '0;
         mem_addr    <= '0;
         mem_size    <= '0;
         mem_wdata   <= '0;
         ld_shift    <= '0;
         ld_keep     <= '0;
      end else if (req_valid) begin
         fpr_dst_idx <= phys_idx;
         fpr_wr_data <= n_fpr_wdata;
         gpr_wr_data <= n_gpr_wdata;
         mem_addr    <= n_addr;
         mem_size    <= word_op ? 4'(WORD_BYTES) : 4'(DWORD_BYTES);
         mem_wdata   <= n_st_data;
         ld_shift    <= n_shift;
         ld_keep     <= n_keep;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> !(fpr_wr_en | gpr_wr_en | mem_valid)); // R1

   AST_EVEN_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !wide_mode && word_op |=> fpr_dst_idx[0] == 1'b0); // R2

   AST_KEEP_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && op == OP_MOVE_IN_W && !wide_mode && reg_num[0]
      |=> fpr_wr_data[HALF-1:0] == $past(fpr_rd_data[HALF-1:0])); // R3

   AST_MOVE_OUT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && op == OP_MOVE_OUT_W
      |=> gpr_wr_data[DATA_W-1:HALF] == {HALF{gpr_wr_data[HALF-1]}}); // R5

   AST_SHIFT_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && ld_shift != '0 |-> mem_size == 4'(WORD_BYTES) && !mem_write); // R6

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fpr_wr_en, gpr_wr_en, mem_valid})); // R10

   AST_ACCEPT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (fpr_wr_en | gpr_wr_en | mem_valid)); // R10

   AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(fpr_wr_en | gpr_wr_en | mem_valid)); // R10

endmodule

// File: tb/tb_fpr_pair_unit.sv
module tb_fpr_pair_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [2:0]  req_op;
   logic        wide_mode;
   logic [4:0]  reg_num;
   logic [4:0]  fpr_rd_idx;
   logic [63:0] fpr_rd_data;
   logic [63:0] gpr_data;
   logic [63:0] base_addr;
   logic [15:0] offset_imm;
   logic        fpr_wr_en;
   logic [4:0]  fpr_dst_idx;
   logic [63:0] fpr_wr_data;
   logic        gpr_wr_en;
   logic [63:0] gpr_wr_data;
   logic        mem_valid;
   logic        mem_write;
   logic [63:0] mem_addr;
   logic [3:0]  mem_size;
   logic [63:0] mem_wdata;
   logic [5:0]  ld_shift;
   logic [63:0] ld_keep;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpr_pair_unit dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .wide_mode(wide_mode), .reg_num(reg_num), .fpr_rd_idx(fpr_rd_idx),
      .fpr_rd_data(fpr_rd_data), .gpr_data(gpr_data), .base_addr(base_addr),
      .offset_imm(offset_imm), .fpr_wr_en(fpr_wr_en), .fpr_dst_idx(fpr_dst_idx),
      .fpr_wr_data(fpr_wr_data), .gpr_wr_en(gpr_wr_en), .gpr_wr_data(gpr_wr_data),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .ld_shift(ld_shift),
      .ld_keep(ld_keep)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] sx(input logic [31:0] w);
      return {{32{w[31]}}, w};
   endfunction

   // One request: drive at a falling edge, check index now, check outputs a cycle later.
   task automatic xfer(input logic v, input logic [2:0] op, input logic wm,
                       input logic [4:0] rn, input logic [63:0] fv,
                       input logic [63:0] gv, input logic [63:0] ba,
                       input logic [15:0] im);
      logic        paired;
      logic        word;
      logic        hi;
      logic [4:0]  idx;
      logic [63:0] e_fw, e_gw, e_sd, e_keep;
      logic [5:0]  e_sh;
      paired = !wm;
      word   = (op == 3'd0) || (op == 3'd1) || (op == 3'd4) || (op == 3'd6);
      hi     = paired && word && rn[0];
      idx    = (paired && word) ? {rn[4:1], 1'b0} : rn;
      e_fw   = gv;
      if (op == 3'd0)
         e_fw = !paired ? sx(gv[31:0]) : (rn[0] ? {gv[31:0], fv[31:0]} : {fv[63:32], gv[31:0]});
      e_gw   = (op == 3'd1) ? sx(hi ? fv[63:32] : fv[31:0]) : fv;
      e_sd   = (op == 3'd6 && hi) ? {32'h0, fv[63:32]} : fv;
      e_keep = 64'h0;
      e_sh   = 6'd0;
      if (op == 3'd4 && paired) begin
         e_keep = rn[0] ? {32'h0, fv[31:0]} : {fv[63:32], 32'h0};
         e_sh   = rn[0] ? 6'd32 : 6'd0;
      end

      req_valid = v; req_op = op; wide_mode = wm; reg_num = rn;
      fpr_rd_data = fv; gpr_data = gv; base_addr = ba; offset_imm = im;
      #1;
      if (v) check("R2 read index", 64'(fpr_rd_idx), 64'(idx));
      @(negedge clk);
      check("R10 fpr strobe", 64'(fpr_wr_en), 64'(v && (op == 3'd0 || op == 3'd2)));
      check("R10 gpr strobe", 64'(gpr_wr_en), 64'(v && (op == 3'd1 || op == 3'd3)));
      check("R10 mem strobe", 64'(mem_valid), 64'(v && op[2]));
      if (!v) return;
      case (op)
         3'd0: begin
            check("R2 dest index", 64'(fpr_dst_idx), 64'(idx));
            check(paired ? "R3 paired move in" : "R4 wide move in", fpr_wr_data, e_fw);
         end
         3'd2: begin
            check("R2 dest index", 64'(fpr_dst_idx), 64'(idx));
            check("R9 move in 64", fpr_wr_data, e_fw);
         end
         3'd1: check("R5 move out word", gpr_wr_data, e_gw);
         3'd3: check("R9 move out 64", gpr_wr_data, e_gw);
         default: begin
            check("R8 address", mem_addr, ba + {{48{im[15]}}, im});
            check("R8 size", 64'(mem_size), word ? 64'd4 : 64'd8);
            check("R8 direction", 64'(mem_write), 64'(op[1]));
            if (!op[1]) begin
               check("R2 load dest", 64'(fpr_dst_idx), 64'(idx));
               check("R6 load shift", 64'(ld_shift), 64'(e_sh));
               check("R6 load keep", ld_keep, e_keep);
            end else begin
               check("R7 store data", mem_wdata, e_sd);
            end
         end
      endcase
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; wide_mode = 1'b0; reg_num = '0;
      fpr_rd_data = '0; gpr_data = '0; base_addr = '0; offset_imm = '0;
      repeat (3) @(negedge clk);
      // R1: quiet during reset and first cycle after
      check("R1 fpr strobe in reset", 64'(fpr_wr_en), 64'd0);
      check("R1 gpr strobe in reset", 64'(gpr_wr_en), 64'd0);
      check("R1 mem strobe in reset", 64'(mem_valid), 64'd0);
      req_valid = 1'b1; req_op = 3'd0;
      @(negedge clk);
      check("R1 still quiet under reset", 64'(fpr_wr_en | gpr_wr_en | mem_valid), 64'd0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 quiet after reset", 64'(fpr_wr_en | gpr_wr_en | mem_valid), 64'd0);

      // Directed corners
      xfer(1, 3'd0, 0, 5'd7,  64'h1111_2222_3333_4444, 64'hFFFF_FFFF_8765_4321, 0, 0); // R3 odd
      xfer(1, 3'd0, 0, 5'd6,  64'h1111_2222_3333_4444, 64'h0000_0000_8765_4321, 0, 0); // R3 even
      xfer(1, 3'd0, 1, 5'd7,  64'h1111_2222_3333_4444, 64'h0000_0000_8765_4321, 0, 0); // R4 negative
      xfer(1, 3'd0, 1, 5'd3,  64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_1234_5678, 0, 0); // R4 positive
      xfer(1, 3'd1, 0, 5'd9,  64'h9ABC_DEF0_0123_4567, 0, 0, 0);                       // R5 odd high
      xfer(1, 3'd1, 1, 5'd9,  64'h0123_4567_9ABC_DEF0, 0, 0, 0);                       // R5 wide low
      xfer(1, 3'd2, 0, 5'd31, 64'h0, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);                  // R9 odd unpaired
      xfer(1, 3'd3, 0, 5'd1,  64'hFEED_FACE_0BAD_F00D, 0, 0, 0);                       // R9
      xfer(1, 3'd4, 0, 5'd5,  64'h5555_6666_7777_8888, 0, 64'h1000, 16'hFFFC);         // R6 R8
      xfer(1, 3'd4, 0, 5'd4,  64'h5555_6666_7777_8888, 0, 64'h1000, 16'h0004);         // R6
      xfer(1, 3'd4, 1, 5'd5,  64'h5555_6666_7777_8888, 0, 64'h1000, 16'h7FFF);         // R6 wide
      xfer(1, 3'd5, 0, 5'd5,  64'h5555_6666_7777_8888, 0, 64'h0, 16'h8000);            // R8 wrap
      xfer(1, 3'd6, 0, 5'd11, 64'hCAFE_BABE_1234_5678, 0, 64'h20, 16'h0);              // R7 odd
      xfer(1, 3'd6, 1, 5'd11, 64'hCAFE_BABE_1234_5678, 0, 64'h20, 16'h0);              // R7 wide
      xfer(1, 3'd7, 0, 5'd11, 64'hCAFE_BABE_1234_5678, 0, 64'h20, 16'h8);              // R7 64
      xfer(0, 3'd0, 0, 5'd2,  64'h0, 64'h0, 0, 0);                                      // R10 idle

      // Seeded random traffic
      for (int i = 0; i < 3000; i++) begin
         xfer(($urandom % 8) != 0, 3'($urandom), 1'($urandom), 5'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, 16'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule